// File: doc/BRIEF.md
# Enable-Triggered Tilt Acquisition Sequencer

This block runs one acquisition for every pulse on its enable input. A rising enable starts a single pass over the three axes in the order X, Y, Z. The pass takes one signed 14-bit, already compensated sample per axis from a simple sample source. The magnitude of each sample is tested against a fixed tilt threshold, and the three results drive per-axis tilt outputs. When the Z axis is done, the block goes on its own into a hold state. The results then stay on the pins until enable falls. A falling enable clears them and releases the pins.

The sample source is steered by `smp_axis`. A one-cycle `store_stb` tells a neighbouring register bank to capture `smp_data` for that axis. `tilt_oe` drives the output enable of the tilt pins. It is high while converting and while holding, and low in shutdown. Enable is asynchronous to `clk` and passes through a synchroniser first. The conversion time for each axis is a parameter.

Top module: `tilt_oneshot_ctrl`

## Requirements
- R1: During and right after synchronous reset, `tilt_oe`, `tilt_out` and `store_stb` are all 0 and `smp_axis` is 0.
- R2: After `en_in` rises, the first `store_stb` appears in the cycle that follows clock edge number SYNC_STAGES+CONV_CYCLES. Edge 1 is the first edge that samples `en_in` high.
- R3: Each rising edge of the synchronised enable starts exactly one pass with exactly three strobes, one per axis, on `smp_axis` codes 0 (X), 1 (Y) and 2 (Z), in that order. Code 3 never appears.
- R4: Consecutive strobes of a pass are exactly CONV_CYCLES cycles apart, and each strobe lasts one cycle.
- R5: An axis result is 1 when |sample| > TILT_THRESH (688) and 0 when |sample| <= 688. So 688 and -688 give 0, and 689 and -689 give 1.
- R6: The magnitude is taken on two's-complement input without overflow. -8192 and 8191 both give 1, and a sample and its negation always give the same result.
- R7: While converting, `tilt_oe` is 1 and all three bits of `tilt_out` are 0.
- R8: After the Z strobe, with enable still high, the block holds the results on its own. From the next cycle `tilt_out` (bit 0 X, bit 1 Y, bit 2 Z) shows the three results and `tilt_oe` is 1.
- R9: While enable stays high in the hold state, `tilt_out` does not change and no strobe occurs, whatever `smp_data` does.
- R10: When enable falls, `tilt_oe` and `tilt_out` go to 0 within SYNC_STAGES+1 cycles and stay 0 until the next acquisition.
- R11: If enable falls during a pass, the pass is abandoned with no further strobes, and the next enable pulse starts a complete new pass from X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_in | input | 1 | Asynchronous acquisition enable |
| smp_data | input | DATA_W | Compensated two's-complement sample for the axis on `smp_axis` |
| smp_axis | output | 2 | Axis being converted: 0 X, 1 Y, 2 Z |
| store_stb | output | 1 | One-cycle strobe: capture `smp_data` for `smp_axis` |
| tilt_out | output | 3 | Per-axis tilt results (bit 0 X, bit 1 Y, bit 2 Z) |
| tilt_oe | output | 1 | Output enable for the tilt pins |

## Verification
The bench builds the block with CONV_CYCLES set to 5, leaving the data width at 14, the threshold at 688 and the synchroniser depth at 2. The short conversion time lets a full pass, the hold phase, a shutdown and an abort fit in a few dozen cycles, so many vector sets can be run. It also lets the bench time an abort so that enable falls between the X and Y strobes. The default width and threshold put both ends of the two's-complement range and the ±688/±689 boundary within reach of the directed vectors.

// File: rtl/tilt_pkg.sv
// Shared types for the tilt acquisition sequencer.
// Assumes three axes, encoded as 2-bit codes in the order they are converted.
package tilt_pkg;
    localparam int NUM_AXES = 3;

    typedef enum logic [1:0] {
        ST_SHUT    = 2'd0,
        ST_ACTIVE  = 2'd1,
        ST_STANDBY = 2'd2
    } acq_state_t;

    typedef enum logic [1:0] {
        AX_X = 2'd0,
        AX_Y = 2'd1,
        AX_Z = 2'd2
    } axis_t;
endpackage

// File: rtl/en_sync_edge.sv
// Brings the asynchronous enable into the clk domain and flags its rising edge.
// Assumes STAGES >= 2. en_rise is combinational from two registered signals.
module en_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_async,
    output logic en_s,
    output logic en_rise
);
    logic [STAGES-1:0] sync_q;
    logic              en_d;

    // Shift the raw enable through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], en_async};
    end

    // Remember the previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) en_d <= 1'b0;
        else        en_d <= sync_q[STAGES-1];
    end

    assign en_s    = sync_q[STAGES-1];
    assign en_rise = en_s & ~en_d;
endmodule

// File: rtl/tilt_mag_cmp.sv
// Combinational magnitude-versus-threshold test for one signed sample.
// The magnitude is one bit wider than the sample, so the most negative code does not wrap.
module tilt_mag_cmp #(
    parameter int DATA_W = 14,
    parameter int THRESH = 688
) (
    input  logic [DATA_W-1:0] sample,
    output logic              over
);
    localparam int MAG_W = DATA_W + 1;

    logic [MAG_W-1:0] ext;
    logic [MAG_W-1:0] mag;

    // Sign-extend, negate when negative, then compare strictly.
    always_comb begin
        ext  = {sample[DATA_W-1], sample};
        mag  = sample[DATA_W-1] ? (~ext + MAG_W'(1)) : ext;
        over = (mag > MAG_W'(THRESH));
    end
endmodule

// File: rtl/acq_seq.sv
// One-shot acquisition state machine: a rising enable starts X, Y, Z conversions,
// each lasting CONV_CYCLES cycles, after which the machine holds until enable drops.
// Assumes CONV_CYCLES >= 2 so that strobes are separated by idle cycles.
module acq_seq
    import tilt_pkg::*;
#(
    parameter int CONV_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_s,
    input  logic       en_rise,
    output acq_state_t state,
    output axis_t      axis,
    output logic       stb
);
    localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CONV_CYCLES - 1);

    acq_state_t        state_n;
    axis_t             axis_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic              running;

    assign running = (state == ST_ACTIVE) && en_s;
    assign stb     = (state == ST_ACTIVE) && (cnt == CNT_LAST);

    // Next state: start on a rising edge, finish after Z, drop out whenever enable is low.
    always_comb begin
        state_n = state;
        case (state)
            ST_SHUT:    if (en_rise) state_n = ST_ACTIVE;
            ST_ACTIVE:  if (!en_s) state_n = ST_SHUT;
                        else if (stb && axis == AX_Z) state_n = ST_STANDBY;
            ST_STANDBY: if (!en_s) state_n = ST_SHUT;
            default:    state_n = ST_SHUT;
        endcase
    end

    // Conversion timer and axis pointer, both parked at zero outside a pass.
    always_comb begin
        cnt_n  = '0;
        axis_n = AX_X;
        if (running) begin
            cnt_n  = stb ? '0 : cnt + CNT_W'(1);
            axis_n = axis;
            if (stb) axis_n = (axis == AX_Z) ? AX_X : axis_t'(axis + 2'd1);
        end
    end

    // Register state, timer and axis pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_SHUT;
            cnt   <= '0;
            axis  <= AX_X;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            axis  <= axis_n;
        end
    end
endmodule

// File: rtl/result_hold.sv
// Per-axis result flops: written on the strobe for the selected axis, cleared while enable is low.
// Clearing takes priority over a write in the same cycle.
module result_hold
    import tilt_pkg::*;
#(
    parameter int AXES = NUM_AXES
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            wr,
    input  axis_t           axis,
    input  logic            bit_in,
    output logic [AXES-1:0] res
);
    for (genvar i = 0; i < AXES; i++) begin : g_axis
        // Hold one axis result.
        always_ff @(posedge clk) begin
            if (!rst_n || clr)                res[i] <= 1'b0;
            else if (wr && axis == axis_t'(i)) res[i] <= bit_in;
        end
    end
endmodule

// File: rtl/tilt_oneshot_ctrl.sv
// Top of the tilt acquisition sequencer. It synchronises enable, runs one X/Y/Z pass per
// rising edge, tests each sample's magnitude and presents the held results on the tilt pins.
// Assumes smp_data is valid for the axis on smp_axis by the end of each conversion window.
module tilt_oneshot_ctrl
    import tilt_pkg::*;
#(
    parameter int DATA_W      = 14,
    parameter int TILT_THRESH = 688,
    parameter int CONV_CYCLES = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_in,
    input  logic [DATA_W-1:0] smp_data,
    output logic [1:0]        smp_axis,
    output logic              store_stb,
    output logic [2:0]        tilt_out,
    output logic              tilt_oe
);
    logic       en_s;
    logic       en_rise;
    acq_state_t state;
    axis_t      axis;
    logic       stb;
    logic       over;
    logic [NUM_AXES-1:0] res;

    en_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .en_async(en_in), .en_s(en_s), .en_rise(en_rise)
    );

    acq_seq #(.CONV_CYCLES(CONV_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .en_s(en_s), .en_rise(en_rise),
        .state(state), .axis(axis), .stb(stb)
    );

    tilt_mag_cmp #(.DATA_W(DATA_W), .THRESH(TILT_THRESH)) u_cmp (
        .sample(smp_data), .over(over)
    );

    result_hold #(.AXES(NUM_AXES)) u_hold (
        .clk(clk), .rst_n(rst_n), .clr(!en_s), .wr(stb),
        .axis(axis), .bit_in(over), .res(res)
    );

    // Pins show results only while holding, and are enabled in any powered state.
    always_comb begin
        smp_axis  = axis;
        store_stb = stb;
        tilt_out  = (state == ST_STANDBY) ? res : 3'b000;
        tilt_oe   = (state != ST_SHUT);
    end
endmodule

// File: rtl/tilt_oneshot_chk.sv
// Assertion checker for tilt_oneshot_ctrl, attached with bind below.
// Observes the top's ports and its synchronised enable.
module tilt_oneshot_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_s,
    input logic [1:0] smp_axis,
    input logic       store_stb,
    input logic [2:0] tilt_out,
    input logic       tilt_oe
);
    // R7: a strobe only occurs mid-pass, with the pins enabled and low.
    a_r7_low_in_active: assert property (@(posedge clk) disable iff (!rst_n)
        store_stb |-> (tilt_oe && tilt_out == 3'b000));

    // R10: a released pin set never shows a result and never strobes.
    a_r10_shut_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tilt_oe |-> (tilt_out == 3'b000 && !store_stb));

    // R4: strobes last one cycle.
    a_r4_single_stb: assert property (@(posedge clk) disable iff (!rst_n)
        store_stb |=> !store_stb);

    // R3: the axis code stays within X, Y, Z.
    a_r3_axis_code: assert property (@(posedge clk) disable iff (!rst_n)
        smp_axis != 2'd3);

    // R8: the Z strobe with enable high leads to the hold state.
    a_r8_auto_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (store_stb && smp_axis == 2'd2 && en_s) |=> (tilt_oe && !store_stb && smp_axis == 2'd0));

    // R9: shown results stay put while enable is high.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tilt_out != 3'b000 && en_s) |=> (tilt_out == $past(tilt_out) && !store_stb));
endmodule

bind tilt_oneshot_ctrl tilt_oneshot_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .smp_axis(smp_axis),
    .store_stb(store_stb), .tilt_out(tilt_out), .tilt_oe(tilt_oe)
);

// File: tb/sim_tilt_oneshot_ctrl.sv
`timescale 1ns/1ps
module sim_tilt_oneshot_ctrl;
    localparam int CONV  = 5;
    localparam int THR   = 688;
    localparam int SYNC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_in = 1'b0;
    logic [13:0] smp_data;
    logic [1:0]  smp_axis;
    logic        store_stb;
    logic [2:0]  tilt_out;
    logic        tilt_oe;

    int vals [3];
    int compared = 0, mismatched = 0, cyc = 0;
    bit done = 0;

    // behavioural reference state
    int m_s1, m_s2, m_d, m_st, m_cnt, m_ax;
    int m_res [3];

    // strobe monitor
    int stb_cnt, first_stb, last_stb, ord;

    always #2 clk = ~clk;

    tilt_oneshot_ctrl #(.DATA_W(14), .TILT_THRESH(THR), .CONV_CYCLES(CONV), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .en_in(en_in), .smp_data(smp_data),
        .smp_axis(smp_axis), .store_stb(store_stb), .tilt_out(tilt_out), .tilt_oe(tilt_oe)
    );

    always_comb begin
        case (smp_axis)
            2'd0:    smp_data = 14'(vals[0]);
            2'd1:    smp_data = 14'(vals[1]);
            default: smp_data = 14'(vals[2]);
        endcase
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int absval(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Reference model, advanced on each rising edge from pre-edge values.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_d = 0; m_st = 0; m_cnt = 0; m_ax = 0;
            foreach (m_res[i]) m_res[i] = 0;
        end else begin
            int rise, stb, n_st, n_cnt, n_ax;
            rise = (m_s2 == 1 && m_d == 0);
            stb  = (m_st == 1 && m_cnt == CONV - 1);
            if (m_s2 == 0) foreach (m_res[i]) m_res[i] = 0;
            else if (stb) m_res[m_ax] = (absval(vals[m_ax]) > THR) ? 1 : 0;
            n_st = m_st;
            if (m_st == 0 && rise) n_st = 1;
            else if (m_st == 1 && m_s2 == 0) n_st = 0;
            else if (m_st == 1 && stb && m_ax == 2) n_st = 2;
            else if (m_st == 2 && m_s2 == 0) n_st = 0;
            n_cnt = 0; n_ax = 0;
            if (m_st == 1 && m_s2 == 1) begin
                n_cnt = stb ? 0 : m_cnt + 1;
                n_ax  = stb ? ((m_ax == 2) ? 0 : m_ax + 1) : m_ax;
            end
            m_st = n_st; m_cnt = n_cnt; m_ax = n_ax;
            m_d = m_s2; m_s2 = m_s1; m_s1 = en_in;
        end
    end

    // Compare every cycle away from the active edge; also log strobes.
    always @(negedge clk) begin
        int e_tilt;
        e_tilt = (m_st == 2) ? (m_res[2] * 4 + m_res[1] * 2 + m_res[0]) : 0;
        compared++;
        if (tilt_oe !== (m_st != 0) || tilt_out !== 3'(e_tilt) ||
            store_stb !== (m_st == 1 && m_cnt == CONV - 1) || smp_axis !== 2'(m_ax)) begin
            mismatched++;
            $display("FAIL R3/R5/R10 cycle %0d: actual oe=%0d tilt=%0d stb=%0d ax=%0d expected oe=%0d tilt=%0d ax=%0d",
                     cyc, tilt_oe, tilt_out, store_stb, smp_axis, (m_st != 0), e_tilt, m_ax);
        end
        if (store_stb) begin
            if (stb_cnt == 0) first_stb = cyc;
            last_stb = cyc;
            stb_cnt++;
            ord = ord * 4 + int'(smp_axis) + 1;
            check(tilt_oe && tilt_out == 3'b000, "R7 pins during pass", int'(tilt_out), 0);
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic acq(input int x, input int y, input int z, input int exp_t);
        int t0;
        vals[0] = x; vals[1] = y; vals[2] = z;
        stb_cnt = 0; ord = 0;
        @(negedge clk);
        en_in = 1'b1; t0 = cyc;
        cycles(3 * CONV + SYNC + 4);
        check(first_stb - t0 == SYNC + CONV, "R2 first strobe latency", first_stb - t0, SYNC + CONV);
        check(stb_cnt == 3 && ord == 27, "R3 strobe count/order", ord, 27);
        check(last_stb - first_stb == 2 * CONV, "R4 strobe spacing", last_stb - first_stb, 2 * CONV);
        check(tilt_oe && int'(tilt_out) == exp_t, "R5 R6 R8 held result", int'(tilt_out), exp_t);
        vals[0] = -vals[0] + 700; vals[1] = 8191; vals[2] = -8192;
        cycles(20);
        check(int'(tilt_out) == exp_t && stb_cnt == 3, "R9 hold ignores source", int'(tilt_out), exp_t);
        en_in = 1'b0;
        cycles(SYNC + 1);
        check(!tilt_oe && tilt_out == 3'b000, "R10 released after enable low", int'(tilt_oe), 0);
        cycles(3);
    endtask

    initial begin
        vals[0] = 0; vals[1] = 0; vals[2] = 0;
        cycles(4);
        check(!tilt_oe && tilt_out == 3'b000 && !store_stb && smp_axis == 2'd0, "R1 reset state", int'(tilt_oe), 0);
        rst_n = 1'b1;
        cycles(2);
        check(!tilt_oe && tilt_out == 3'b000 && !store_stb, "R1 after reset", int'(tilt_out), 0);
        acq(688, -688, 689, 3'b100);     // R5 boundaries
        acq(-689, 0, -8192, 3'b101);     // R6 most negative
        acq(8191, 1000, -1000, 3'b111);  // R6 symmetry
        acq(0, 687, -1, 3'b000);         // R5 all below
        // R11 abort between the X and Y strobes
        vals[0] = 900; vals[1] = 900; vals[2] = 900;
        stb_cnt = 0; ord = 0;
        en_in = 1'b1;
        cycles(CONV + SYNC + 2);
        en_in = 1'b0;
        cycles(3 * CONV + 6);
        check(stb_cnt == 1 && !tilt_oe, "R11 abort stops strobes", stb_cnt, 1);
        acq(-900, 100, 900, 3'b101);     // R11 fresh pass after abort
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule